// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Array

This block is one output cell of a small programmable sum-of-products logic device, together with the OR gate that collects its product terms. It receives eight product-term values from the AND array. It also takes a mask that switches individual terms off, two architecture bits shared across the device, and two bits that belong to this cell. From these it produces the value driven onto its pin, the enable of the pin driver, and the signal it feeds back into the AND array.

The architecture bits put the cell into one of four modes: clocked (registered) output, combinatorial input/output, always-driven combinatorial output, or input only. The mode decides three things: where the output enable comes from, whether the lowest product term is a data term or the enable term, and which signal is fed back. In registered mode the OR result, after the polarity stage, is captured on each rising clock edge. All other results are combinatorial.

The cell has no data stream, so it carries no valid/ready handshake. Every pin is plain control or level data, and no back-pressure exists.

Top module: `pldmc_cell`

## Requirements
- R1: While `rst_n` is low, the register holds 0 asynchronously. In registered mode `pin_out` and `fb_out` therefore read 1.
- R2: The OR result is the OR of the enabled product terms. A term whose `term_off` bit is 1 contributes 0.
- R3: The polarity stage passes the OR result unchanged when `cell_xor` is 0 and inverts it when `cell_xor` is 1.
- R4: Modes decode as follows. `glb_sync`=1 with `cell_sel`=0 selects registered. `glb_sync`=1 with `cell_sel`=1 selects combinatorial I/O. `glb_sync`=0 with `glb_cplx`=1 selects combinatorial I/O whatever the value of `cell_sel`. `glb_sync`=0, `glb_cplx`=0 and `cell_sel`=0 selects combinatorial output. `glb_sync`=0, `glb_cplx`=0 and `cell_sel`=1 selects input only.
- R5: In registered mode the register captures the polarity-stage value on every rising edge. `pin_out` is the inverse of the register and changes only after a rising edge.
- R6: In registered mode `pin_oe` is the inverse of the active-low pin `oe_n`, with no clock.
- R7: In combinatorial I/O mode, term 0 (bit 0 of `term_in`) drives `pin_oe` and is left out of the OR. When its `term_off` bit is set, the enable is 0.
- R8: In combinatorial output mode `pin_oe` is always 1, and all eight terms feed the OR.
- R9: In input-only mode `pin_oe` and `pin_out` are both 0.
- R10: `fb_out` depends on the mode. In registered mode it is the inverted register. In combinatorial I/O mode it is `pin_in`. In combinatorial output and input-only modes it is `adj_in`.
- R11: In every mode other than registered, `pin_out` follows the terms and polarity in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the register |
| term_in | input | N_TERMS | Product-term values from the AND array; bit 0 is term 0 |
| term_off | input | N_TERMS | Per-term disable, 1 = term forced to 0 |
| glb_sync | input | 1 | Global architecture bit: registered-capable device |
| glb_cplx | input | 1 | Global architecture bit: all cells combinatorial I/O |
| cell_sel | input | 1 | Local architecture bit choosing the cell's mode |
| cell_xor | input | 1 | Local polarity bit, 1 = invert |
| oe_n | input | 1 | External active-low output-enable pin |
| pin_in | input | 1 | Value currently on this cell's pin |
| adj_in | input | 1 | Value currently on the adjacent cell's pin |
| pin_out | output | 1 | Value to drive onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback into the AND array |

## Verification
Every combinatorial result, which includes all of `pin_oe`, `fb_out` outside registered mode, and `pin_out` in the three combinatorial modes, is due in the same cycle as the input change. The bench drives on the falling edge and samples one nanosecond later, with no clock edge in between. In registered mode `pin_out` and `fb_out` are due one rising edge after the terms change. The bench checks them once before that edge, where they must still hold the old value, and again one nanosecond after it. Reset behaviour is sampled both while `rst_n` is low and after an asynchronous reset applied mid-run.

// File: rtl/pldmc_pkg.sv
package pldmc_pkg;
  typedef enum logic [1:0] {
    MODE_REG  = 2'd0,
    MODE_CIO  = 2'd1,
    MODE_COUT = 2'd2,
    MODE_DIN  = 2'd3
  } cell_mode_e;

  typedef enum logic [1:0] {
    FB_REG = 2'd0,
    FB_OWN = 2'd1,
    FB_ADJ = 2'd2
  } fb_src_e;
endpackage

// File: rtl/pldmc_decode.sv
module pldmc_decode
  import pldmc_pkg::*;
(
  input  logic       glb_sync,
  input  logic       glb_cplx,
  input  logic       cell_sel,
  output cell_mode_e mode,
  output logic       skip_first,
  output fb_src_e    fb_src
);
  always_comb begin
    if (glb_sync)      mode = cell_sel ? MODE_CIO : MODE_REG;
    else if (glb_cplx) mode = MODE_CIO;
    else               mode = cell_sel ? MODE_DIN : MODE_COUT;
  end

  always_comb begin
    skip_first = (mode == MODE_CIO);
    unique case (mode)
      MODE_REG: fb_src = FB_REG;
      MODE_CIO: fb_src = FB_OWN;
      default:  fb_src = FB_ADJ;
    endcase
  end
endmodule

// File: rtl/pldmc_or.sv
module pldmc_or #(
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] term_in,
  input  logic [N_TERMS-1:0] term_off,
  input  logic               skip_first,
  output logic               sum,
  output logic               first_live
);
  localparam int FIRST = 0;

  logic [N_TERMS-1:0] live;
  logic [N_TERMS-1:0] data;

  for (genvar i = 0; i < N_TERMS; i++) begin : g_term
    assign live[i] = term_in[i] & ~term_off[i];
    if (i == FIRST) begin : g_first
      assign data[i] = live[i] & ~skip_first;
    end else begin : g_rest
      assign data[i] = live[i];
    end
  end

  assign sum        = |data;
  assign first_live = live[FIRST];
endmodule

// File: rtl/pldmc_outreg.sv
module pldmc_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

  assert_q_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q == $past(d)));

  assert_q_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (q == 1'b0));
endmodule

// File: rtl/pldmc_cell.sv
module pldmc_cell
  import pldmc_pkg::*;
#(
  parameter int N_TERMS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TERMS-1:0] term_in,
  input  logic [N_TERMS-1:0] term_off,
  input  logic               glb_sync,
  input  logic               glb_cplx,
  input  logic               cell_sel,
  input  logic               cell_xor,
  input  logic               oe_n,
  input  logic               pin_in,
  input  logic               adj_in,
  output logic               pin_out,
  output logic               pin_oe,
  output logic               fb_out
);
  cell_mode_e mode;
  fb_src_e    fb_src;
  logic       skip_first;
  logic       sum;
  logic       first_live;
  logic       pol;
  logic       q;

  pldmc_decode u_dec (
    .glb_sync   (glb_sync),
    .glb_cplx   (glb_cplx),
    .cell_sel   (cell_sel),
    .mode       (mode),
    .skip_first (skip_first),
    .fb_src     (fb_src)
  );

  pldmc_or #(.N_TERMS(N_TERMS)) u_or (
    .term_in    (term_in),
    .term_off   (term_off),
    .skip_first (skip_first),
    .sum        (sum),
    .first_live (first_live)
  );

  assign pol = sum ^ cell_xor;

  pldmc_outreg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pol),
    .q     (q)
  );

  always_comb begin
    unique case (mode)
      MODE_REG: begin pin_oe = ~oe_n;      pin_out = ~q;  end
      MODE_CIO: begin pin_oe = first_live; pin_out = pol; end
      MODE_COUT: begin pin_oe = 1'b1;      pin_out = pol; end
      default:  begin pin_oe = 1'b0;       pin_out = 1'b0; end
    endcase
  end

  always_comb begin
    unique case (fb_src)
      FB_REG:  fb_out = ~q;
      FB_OWN:  fb_out = pin_in;
      default: fb_out = adj_in;
    endcase
  end

  assert_reg_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode == MODE_REG) |-> (pin_out == ~$past(pol)));

  assert_reg_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_REG) |-> (pin_oe == ~oe_n));

  assert_cout_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_COUT) |-> pin_oe);

  assert_din_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DIN) |-> (!pin_oe && !pin_out));

  assert_cio_fb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CIO) |-> (fb_out == pin_in));

  assert_cio_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CIO && term_off[0]) |-> !pin_oe);
endmodule

// File: tb/pldmc_cell_test.sv
module pldmc_cell_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] term_in, term_off;
  logic       glb_sync, glb_cplx, cell_sel, cell_xor, oe_n, pin_in, adj_in;
  logic       pin_out, pin_oe, fb_out;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  pldmc_cell #(.N_TERMS(8)) uut (
    .clk(clk), .rst_n(rst_n), .term_in(term_in), .term_off(term_off),
    .glb_sync(glb_sync), .glb_cplx(glb_cplx), .cell_sel(cell_sel),
    .cell_xor(cell_xor), .oe_n(oe_n), .pin_in(pin_in), .adj_in(adj_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  // {sync,cplx,sel,xor, oe_n,pin_in,adj_in, terms[7:0], off[7:0], e_oe,e_out,e_fb}
  localparam int NV = 11;
  localparam logic [25:0] VEC [NV] = '{
    26'b0000_101_00000000_00000000_101, // R8 cout, nothing set
    26'b0000_110_10000000_00000000_110, // R2 term7 live
    26'b0000_101_10000000_10000000_101, // R2 term7 disabled
    26'b0001_110_00000000_00000000_110, // R3 inverted zero
    26'b0001_101_00000001_00000000_101, // R3 term0 as data, inverted
    26'b0010_110_11111111_00000000_000, // R9 input only, fb adjacent
    26'b0100_110_00000001_00000000_101, // R7 cplx: term0 enables, not summed
    26'b0110_101_00000010_00000000_010, // R4 cplx ignores cell_sel
    26'b1010_110_00000011_00000001_011, // R7 sync+sel: term0 disabled
    26'b1011_100_00000001_00000000_110, // R3 cio inverted, fb own pin
    26'b0000_100_11111111_11111111_100  // R2 all disabled
  };

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; term_in = '0; term_off = '0;
    glb_sync = 1'b1; glb_cplx = 1'b0; cell_sel = 1'b0; cell_xor = 1'b0;
    oe_n = 1'b0; pin_in = 1'b0; adj_in = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R1", "pin_out in reset", pin_out, 1'b1);
    check("R1", "fb_out in reset", fb_out, 1'b1);
    check("R6", "oe follows oe_n low", pin_oe, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // table of combinatorial vectors
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {glb_sync, glb_cplx, cell_sel, cell_xor} = VEC[k][25:22];
      {oe_n, pin_in, adj_in} = VEC[k][21:19];
      term_in  = VEC[k][18:11];
      term_off = VEC[k][10:3];
      #1;
      check("R4/R7/R8/R9", $sformatf("vec %0d pin_oe", k), pin_oe, VEC[k][2]);
      check("R2/R3/R11", $sformatf("vec %0d pin_out", k), pin_out, VEC[k][1]);
      check("R10", $sformatf("vec %0d fb_out", k), fb_out, VEC[k][0]);
    end

    // R11: combinatorial change within one low phase, no edge
    @(negedge clk);
    {glb_sync, glb_cplx, cell_sel, cell_xor} = 4'b0000;
    term_off = '0; term_in = 8'h00;
    #1; check("R11", "cout low", pin_out, 1'b0);
    term_in = 8'h10;
    #1; check("R11", "cout high without edge", pin_out, 1'b1);

    // registered mode
    @(negedge clk);
    {glb_sync, glb_cplx, cell_sel, cell_xor} = 4'b1000;
    oe_n = 1'b1; term_in = 8'h00; term_off = 8'h00;
    #1; check("R6", "oe with oe_n high", pin_oe, 1'b0);
    @(posedge clk); #1;
    check("R5", "pin after capturing 0", pin_out, 1'b1);
    @(negedge clk); term_in = 8'h01; oe_n = 1'b0;
    #1;
    check("R5", "pin before edge unchanged", pin_out, 1'b1);
    check("R6", "oe with oe_n low", pin_oe, 1'b1);
    @(posedge clk); #1;
    check("R5", "pin after capturing 1 (term0 is data)", pin_out, 1'b0);
    check("R10", "fb is inverted register", fb_out, 1'b0);
    @(negedge clk); term_off = 8'h01;
    @(posedge clk); #1;
    check("R2", "registered disabled term", pin_out, 1'b1);
    @(negedge clk); cell_xor = 1'b1;
    #1; check("R5", "xor before edge holds", pin_out, 1'b1);
    @(posedge clk); #1;
    check("R3", "registered inverted polarity", pin_out, 1'b0);
    check("R10", "fb tracks register", fb_out, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1", "async reset pin", pin_out, 1'b1);
    check("R1", "async reset fb", fb_out, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R5", "capture after reset release", pin_out, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule